// File: doc/BRIEF.md
# Three-Wire Wiper Position Controller

This block is the digital control section of a 32-step digitally controlled potentiometer. A host drives three slow, asynchronous pins: an active-low select, a direction level and a step strobe. The block synchronises them to the system clock and keeps a 5-bit wiper position. While the block is selected, each falling edge of the strobe moves the position one tap up or down. The position stops at both ends and never wraps. The position is decoded into a registered one-hot tap-select vector that drives the switch network of the resistor array.

A register stands in for the nonvolatile cell. When the select pin is released, the level of the strobe at that moment decides what happens. If the strobe is high, a timed store cycle copies the position into the register. If the strobe is low, the block returns to standby and stores nothing. Reset loads the position from that register, so after reset the wiper comes back to the last committed tap. During a store, a busy flag is raised and pin activity is ignored. Standby is reported when the block is idle and waiting to be selected again.

Top module: `wiper_ctrl`

## Requirements
- R1: During reset, and once it is released, the position equals the stored register. The stored register holds DEFAULT_POS (16) until the first store completes. After reset, busy_o is 0 and standby_o is 1.
- R2: While the synchronised select is low and no store is running, each falling edge of the step pin changes the position by one tap: up when dir_up_i is 1, down when it is 0.
- R3: While the synchronised select is high, step edges have no effect on the position.
- R4: A step down at tap 0 leaves the position at 0. A step up at tap 31 leaves it at 31.
- R5: tap_sel_o always has exactly one bit set, at bit index equal to the position. It follows a position change one clock later.
- R6: A rising edge of the select pin while the step pin is high starts a store. busy_o is 1 for exactly STORE_CYCLES clocks. At the end of the store the position is written into the stored register, and a later reset recalls that value.
- R7: A rising edge of the select pin while the step pin is low does not store. busy_o stays 0, the position is kept, and a later reset recalls the previously stored value.
- R8: While busy_o is 1, step edges and select edges are ignored. The position does not change and no new store starts.
- R9: standby_o goes to 1 when a store completes or on a no-store deselect. It goes to 0 on a falling edge of the select pin while no store is running. A select that falls during a store leaves standby_o at 1 after the store ends, until the next select edge.
- R10: dir_up_i may change at any time while the block stays selected. Mixed up and down moves in one selection each follow the direction level present at their own step edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; reloads position from the stored register |
| sel_n_i | input | 1 | Asynchronous active-low select pin |
| dir_up_i | input | 1 | Asynchronous direction level, 1 = up |
| step_i | input | 1 | Asynchronous step strobe, acts on falling edges |
| pos_o | output | 5 | Current wiper position |
| tap_sel_o | output | 32 | Registered one-hot tap select |
| busy_o | output | 1 | Store cycle in progress |
| standby_o | output | 1 | Idle, waiting for the next select |

## Verification
A wrong position counter shows on pos_o about three clocks after the offending step edge, and on tap_sel_o one clock after that. A missed saturation shows as a jump from 31 to 0 or from 0 to 31. A fault in the store path does not show at once. It shows as a busy pulse of the wrong length, or only after the next reset, when the recalled position differs from the last committed tap. That is why the bench resets often and compares the recalled value against its own record of committed stores. Leaks of pin activity during a store show as a position change or as a wrong standby level once busy_o falls.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

  // Saturating one-tap move; no wrap at either end.
  function automatic int unsigned sat_step(int unsigned pos, logic up, int unsigned max_pos);
    if (up) return (pos >= max_pos) ? max_pos : pos + 1;
    else    return (pos == 0) ? 0 : pos - 1;
  endfunction

endpackage

// File: rtl/wiper_sync.sv
module wiper_sync #(
  parameter int           WIDTH     = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o,
  output logic [WIDTH-1:0] prev_o
);
  logic [WIDTH-1:0] meta_q, sync_q, prev_q;

  // Two flops for synchronisation, one more as edge history.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
      prev_q <= RST_VAL;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign sync_o = sync_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/wiper_counter.sv
module wiper_counter #(
  parameter int POS_W   = 5,
  parameter int MAX_POS = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [POS_W-1:0] load_val_i,
  input  logic             step_en_i,
  input  logic             up_i,
  output logic [POS_W-1:0] pos_o
);
  logic [POS_W-1:0] pos_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         pos_q <= load_val_i;
    else if (step_en_i) pos_q <= POS_W'(wiper_pkg::sat_step(int'(pos_q), up_i, MAX_POS));
  end

  assign pos_o = pos_q;

  assert_step_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step_en_i && up_i && (pos_q != POS_W'(MAX_POS)) |=> pos_q == $past(pos_q) + 1'b1);
  assert_step_dn_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step_en_i && !up_i && (pos_q != '0) |=> pos_q == $past(pos_q) - 1'b1);
  assert_sat_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step_en_i && up_i && (pos_q == POS_W'(MAX_POS)) |=> pos_q == POS_W'(MAX_POS));
  assert_sat_bot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step_en_i && !up_i && (pos_q == '0) |=> pos_q == '0);
endmodule

// File: rtl/wiper_decoder.sv
module wiper_decoder #(
  parameter int POS_W = 5,
  parameter int NTAPS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [POS_W-1:0] pos_i,
  output logic [NTAPS-1:0] tap_o
);
  logic [NTAPS-1:0] tap_d, tap_q;

  for (genvar i = 0; i < NTAPS; i++) begin : g_tap
    assign tap_d[i] = (pos_i == POS_W'(i));
  end

  always_ff @(posedge clk) tap_q <= tap_d;

  assign tap_o = tap_q;

  assert_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tap_q) == 1);
endmodule

// File: rtl/wiper_store.sv
module wiper_store #(
  parameter int POS_W        = 5,
  parameter int DEFAULT_POS  = 16,
  parameter int STORE_CYCLES = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_rise_i,
  input  logic             sel_fall_i,
  input  logic             step_lvl_i,
  input  logic [POS_W-1:0] pos_i,
  output logic [POS_W-1:0] nv_pos_o,
  output logic             busy_o,
  output logic             standby_o,
  output logic             store_done_o
);
  localparam int TMR_W = $clog2(STORE_CYCLES + 1);

  // Stand-in for the nonvolatile cell: not cleared by reset.
  logic [POS_W-1:0] nv_q = POS_W'(DEFAULT_POS);
  logic [TMR_W-1:0] tmr_q;
  logic             busy_q, standby_q;
  logic             start_w, skip_w, done_w;

  assign start_w = sel_rise_i && !busy_q &&  step_lvl_i;
  assign skip_w  = sel_rise_i && !busy_q && !step_lvl_i;
  assign done_w  = busy_q && (tmr_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      standby_q <= 1'b1;
      tmr_q     <= '0;
    end else if (start_w) begin
      busy_q    <= 1'b1;
      tmr_q     <= TMR_W'(STORE_CYCLES - 1);
    end else if (done_w) begin
      busy_q    <= 1'b0;
      standby_q <= 1'b1;
    end else if (busy_q) begin
      tmr_q     <= tmr_q - 1'b1;
    end else if (skip_w) begin
      standby_q <= 1'b1;
    end else if (sel_fall_i) begin
      standby_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && done_w) nv_q <= pos_i;
  end

  assign nv_pos_o     = nv_q;
  assign busy_o       = busy_q;
  assign standby_o    = standby_q;
  assign store_done_o = done_w;

  // Length of the busy window, checked with a run counter.
  logic [TMR_W:0] busy_run_q;
  always_ff @(posedge clk) begin
    if (!rst_n)      busy_run_q <= '0;
    else if (busy_q) busy_run_q <= busy_run_q + 1'b1;
    else             busy_run_q <= '0;
  end

  assert_busy_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> busy_run_q == (TMR_W+1)'(STORE_CYCLES));
  assert_nv_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !done_w |=> $stable(nv_q));
  assert_standby_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_w |=> standby_q && !busy_q);
  assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !done_w |=> busy_q);
endmodule

// File: rtl/wiper_ctrl.sv
module wiper_ctrl #(
  parameter int NTAPS        = 32,
  parameter int DEFAULT_POS  = 16,
  parameter int STORE_CYCLES = 48,
  localparam int POS_W       = $clog2(NTAPS),
  localparam int MAX_POS     = NTAPS - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_n_i,
  input  logic             dir_up_i,
  input  logic             step_i,
  output logic [POS_W-1:0] pos_o,
  output logic [NTAPS-1:0] tap_sel_o,
  output logic             busy_o,
  output logic             standby_o
);
  localparam int SEL = 2, DIR = 1, STP = 0;

  logic [2:0]       pin_s, pin_p;
  logic [POS_W-1:0] pos_w, nv_w;
  logic             busy_w, standby_w, store_done_w;
  logic             sel_rise_w, sel_fall_w, step_fall_w, step_evt_w;

  wiper_sync #(.WIDTH(3), .RST_VAL(3'b111)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_i({sel_n_i, dir_up_i, step_i}),
    .sync_o(pin_s), .prev_o(pin_p)
  );

  assign sel_rise_w  =  pin_s[SEL] && !pin_p[SEL];
  assign sel_fall_w  = !pin_s[SEL] &&  pin_p[SEL];
  assign step_fall_w = !pin_s[STP] &&  pin_p[STP];
  assign step_evt_w  = step_fall_w && !pin_s[SEL] && !busy_w;

  wiper_counter #(.POS_W(POS_W), .MAX_POS(MAX_POS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load_val_i(nv_w),
    .step_en_i(step_evt_w), .up_i(pin_s[DIR]), .pos_o(pos_w)
  );

  wiper_store #(.POS_W(POS_W), .DEFAULT_POS(DEFAULT_POS), .STORE_CYCLES(STORE_CYCLES)) u_store (
    .clk(clk), .rst_n(rst_n),
    .sel_rise_i(sel_rise_w), .sel_fall_i(sel_fall_w), .step_lvl_i(pin_s[STP]),
    .pos_i(pos_w), .nv_pos_o(nv_w), .busy_o(busy_w),
    .standby_o(standby_w), .store_done_o(store_done_w)
  );

  wiper_decoder #(.POS_W(POS_W), .NTAPS(NTAPS)) u_dec (
    .clk(clk), .rst_n(rst_n), .pos_i(pos_w), .tap_o(tap_sel_o)
  );

  assign pos_o     = pos_w;
  assign busy_o    = busy_w;
  assign standby_o = standby_w;

  assert_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !step_evt_w |=> $stable(pos_w));
  assert_busy_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_w |=> $stable(pos_w));
  assert_tap_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tap_sel_o[$past(pos_w)] == 1'b1);
  assert_store_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    store_done_w |=> nv_w == $past(pos_w));
endmodule

// File: tb/wiper_ctrl_tb.sv
module wiper_ctrl_tb;
  localparam int NT    = 32;
  localparam int STORE = 48;
  localparam int DEF   = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1, dir_up = 1'b1, step = 1'b1;
  logic [4:0]    pos;
  logic [NT-1:0] tap;
  logic          busy, standby;

  int checks = 0, fails = 0;
  int exp_pos = DEF, exp_nv = DEF;
  bit exp_sb = 1'b1;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wiper_ctrl #(.NTAPS(NT), .DEFAULT_POS(DEF), .STORE_CYCLES(STORE)) u_dut (
    .clk(clk), .rst_n(rst_n), .sel_n_i(sel_n), .dir_up_i(dir_up), .step_i(step),
    .pos_o(pos), .tap_sel_o(tap), .busy_o(busy), .standby_o(standby)
  );

  function automatic int model_step(int p, bit up);
    if (up) return (p == NT-1) ? p : p + 1;
    return (p == 0) ? 0 : p - 1;
  endfunction

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(bit ok, string tag, longint act, longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic check_pos(string tag);
    logic [NT-1:0] et;
    et = '0;
    et[exp_pos] = 1'b1;
    check(pos == 5'(exp_pos), tag, pos, exp_pos);
    check(tap == et, "R5 tap", tap, et);
  endtask

  task automatic pulse(bit up);
    dir_up = up;
    tick(3);
    step = 1'b0;
    tick(4);
    if (!sel_n) exp_pos = model_step(exp_pos, up);
    step = 1'b1;
    tick(4);
    check_pos(sel_n ? "R3 unselected step" : "R2 R4 R10 step");
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick(1);
    sel_n = 1'b1; step = 1'b1;
    tick(4);
    rst_n = 1'b1;
    tick(4);
    exp_pos = exp_nv;
    exp_sb  = 1'b1;
    check_pos("R1 recall");
    check(standby == 1'b1, "R1 standby", standby, 1);
    check(busy == 1'b0, "R1 busy", busy, 0);
  endtask

  task automatic do_select();
    sel_n = 1'b0;
    tick(6);
    exp_sb = 1'b0;
    check(standby == 1'b0, "R9 select", standby, 0);
  endtask

  task automatic deselect_nostore(bit up);
    dir_up = up;
    tick(3);
    step = 1'b0;
    tick(4);
    exp_pos = model_step(exp_pos, up);
    sel_n = 1'b1;
    tick(4);
    step = 1'b1;
    tick(4);
    exp_sb = 1'b1;
    check(busy == 1'b0, "R7 no busy", busy, 0);
    check(standby == 1'b1, "R9 standby nostore", standby, 1);
    check_pos("R7 kept");
  endtask

  // mode 0: plain store, 1: poke pins during busy and reselect, 2: leave selected
  task automatic deselect_store(int mode);
    int cnt = 0;
    step = 1'b1;
    dir_up = 1'b1;
    tick(4);
    sel_n = 1'b1;
    for (int c = 0; c < STORE + 20; c++) begin
      tick(1);
      if (busy) cnt++;
      if (mode != 0 && c == 8) begin step = 1'b0; sel_n = 1'b0; end
      if (mode != 0 && c == 14) step = 1'b1;
      if (mode == 1 && c == 20) sel_n = 1'b1;
    end
    exp_nv = exp_pos;
    exp_sb = 1'b1;
    check(cnt == STORE, "R6 busy length", cnt, STORE);
    check(standby == 1'b1, "R9 standby after store", standby, 1);
    check_pos(mode != 0 ? "R8 ignored during busy" : "R6 pos after store");
  endtask

  initial begin
    int unsigned r;
    void'($urandom(32'd20241));
    tick(5);
    rst_n = 1'b1;
    tick(4);
    check_pos("R1 default");
    check(standby == 1'b1, "R1 standby", standby, 1);
    check(busy == 1'b0, "R1 busy", busy, 0);

    pulse(1'b1);            // unselected: R3
    do_select();
    for (int i = 0; i < 18; i++) pulse(1'b1);   // saturate top R4
    check(pos == 5'd31, "R4 top", pos, 31);
    for (int i = 0; i < 35; i++) pulse(1'b0);   // saturate bottom R4
    check(pos == 5'd0, "R4 bottom", pos, 0);
    pulse(1'b1); pulse(1'b1); pulse(1'b0);      // R10 mixed
    deselect_store(0);
    do_reset();
    check(pos == 5'(exp_nv), "R6 recall", pos, exp_nv);
    do_select();
    pulse(1'b1);
    deselect_nostore(1'b1);
    do_reset();
    check(pos == 5'(exp_nv), "R7 old value recalled", pos, exp_nv);
    do_select();
    deselect_store(2);
    check(standby == 1'b1, "R9 select during busy ignored", standby, 1);
    pulse(1'b0);
    deselect_nostore(1'b0);
    do_select();
    deselect_store(1);

    for (int i = 0; i < 250; i++) begin
      r = $urandom_range(0, 11);
      if (r <= 6) pulse(1'($urandom_range(0, 1)));
      else if (r == 7) begin
        if (sel_n) do_select();
        else deselect_nostore(1'($urandom_range(0, 1)));
      end
      else if (r == 8) do_reset();
      else if (r == 9) begin
        if (sel_n) do_select();
        deselect_store(0);
      end
      else if (r == 10) begin
        if (sel_n) do_select();
        deselect_store(1);
      end
      else begin
        check(standby == exp_sb, "R9 standby level", standby, exp_sb);
        check(busy == 1'b0, "R8 idle busy", busy, 0);
      end
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule